// File: doc/BRIEF.md
# Multi-Queue FIFO Write Front End

This block is the write side of a FIFO that keeps many logical queues in one shared memory. A single data bus, an active-low write enable and one clock feed every queue. A separate select strobe and address bus choose which queue receives data. Each queue owns a fixed region of the shared RAM, with its own write pointer and occupancy counter. A discrete full flag always describes the queue that is currently active.

A queue change goes through a fixed pipeline. The select takes effect a set number of edges after the address is captured. Writes go on without a gap during that time and still land in the old queue. When the active queue changes, the full flag changes on the same edge to show the new queue, so a switch onto a full queue blocks writes at once. A per-queue free input stands in for the read side and returns one slot per pulse. A registered lookup port returns any stored word, so the read logic can fetch data.

Top module: `mq_write_port`

## Requirements
- R1: While `rst` is high on a clock edge, the block empties every queue, returns every write pointer to slot 0, makes queue 0 active and drives `full_flag` low. All of this is visible after that edge.
- R2: A select is captured on any edge where `sel_en` is high, whatever the state of `wr_en_n`. `active_q` shows the captured address after the fourth edge, counting the capture edge as the first (SW_LAT = 4).
- R3: Writes on the capture edge and on the next three edges go to the previously active queue. The first write to the new queue is on the fifth edge.
- R4: A write happens on an edge where `wr_en_n` is low and the active queue is not full. The word is stored at the queue's write pointer, and the pointer then advances, wrapping from DEPTH-1 to 0. `look_data` returns the word at queue `look_q`, slot `look_slot` one edge after the address is applied.
- R5: An edge with `wr_en_n` high stores nothing and changes no count or pointer.
- R6: `full_flag` is high exactly when the active queue holds DEPTH words. It changes after the edge that makes this true or false.
- R7: On the edge where `active_q` changes, `full_flag` changes with it to give the state of the newly active queue.
- R8: A write to a full queue is discarded. The queue's count, its pointer and the stored words stay unchanged.
- R9: A high bit `free_req[q]` removes one word from queue q on that edge. It has no effect when queue q is empty. A write and a free on the same queue on the same edge leave its count unchanged.
- R10: Selects captured on consecutive edges each take effect four edges after their own capture, in order.
- R11: The active queue stays the same until a later select takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en_n | input | 1 | Write enable, active low |
| wr_data | input | DW | Word to write |
| sel_en | input | 1 | Queue select strobe |
| sel_addr | input | QAW | Queue address sampled with the strobe |
| free_req | input | NQ | One bit per queue; each pulse frees one word |
| look_q | input | QAW | Queue of the word to look up |
| look_slot | input | PW | Slot of the word to look up |
| full_flag | output | 1 | Full status of the active queue |
| active_q | output | QAW | Queue that currently receives writes |
| look_data | output | DW | Looked-up word, one edge after the address |

## Verification
The bench aims at the switch window. It writes on every edge while a select is in flight and then reads back which queue got each word. A design with a pipeline one stage too short or too long would put a word into the wrong queue. A second target is a switch onto a full queue and off it again, with writes held low. A design whose flag lags the active queue would overwrite slot 0 of the full queue, or it would drop a legal write into an empty one. Back-to-back selects, frees on empty queues and a long random phase round out the bench. They catch pipelines that merge selects, counters that underflow, and a write pointer that moves on a rejected write.

// File: rtl/mq_pkg.sv
`timescale 1ns/1ps
package mq_pkg;
  // width of a counter that must hold values 0..n
  function automatic int unsigned cnt_width(input int unsigned n);
    return $clog2(n + 1);
  endfunction

  // width of an index into n entries, never below 1
  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/mq_sel_pipe.sv
`timescale 1ns/1ps
module mq_sel_pipe #(
  parameter int unsigned NQ  = 128,
  parameter int unsigned QAW = 7,
  parameter int unsigned LAT = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sel_en,
  input  logic [QAW-1:0] sel_addr,
  output logic [QAW-1:0] act_q,
  output logic [QAW-1:0] act_next
);
  localparam int unsigned NST = LAT - 1;

  logic           take;
  logic [NST-1:0] st_v;
  logic [QAW-1:0] st_a [NST];

  // filter addresses beyond the queue count only when they can exist
  generate
    if ((1 << QAW) == NQ) begin : g_full_range
      assign take = sel_en;
    end else begin : g_partial_range
      assign take = sel_en && (32'(sel_addr) < NQ);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      st_v  <= '0;
      act_q <= '0;
    end else begin
      st_v[0] <= take;
      for (int i = 1; i < NST; i++) begin
        st_v[i] <= st_v[i-1];
      end
      if (st_v[NST-1]) begin
        act_q <= st_a[NST-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    st_a[0] <= sel_addr;
    for (int i = 1; i < NST; i++) begin
      st_a[i] <= st_a[i-1];
    end
  end

  assign act_next = st_v[NST-1] ? st_a[NST-1] : act_q;
endmodule

// File: rtl/mq_occupancy.sv
`timescale 1ns/1ps
module mq_occupancy #(
  parameter int unsigned NQ    = 128,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned QAW   = 7,
  parameter int unsigned PW    = 4,
  parameter int unsigned CW    = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [QAW-1:0] act_q,
  input  logic [QAW-1:0] act_next,
  input  logic           wr_req,
  input  logic [NQ-1:0]  free_req,
  output logic           wr_fire,
  output logic [PW-1:0]  wr_slot,
  output logic           full_flag
);
  localparam logic [CW-1:0] CNT_MAX  = CW'(DEPTH);
  localparam logic [PW-1:0] SLOT_TOP = PW'(DEPTH - 1);

  logic [CW-1:0] cnt    [NQ];
  logic [CW-1:0] cnt_nx [NQ];
  logic [PW-1:0] wptr   [NQ];
  logic          cur_full;

  assign cur_full = (cnt[act_q] == CNT_MAX);
  assign wr_fire  = wr_req && !cur_full;
  assign wr_slot  = wptr[act_q];

  always_comb begin
    for (int q = 0; q < NQ; q++) begin
      cnt_nx[q] = cnt[q];
      if (wr_fire && (32'(act_q) == q)) begin
        cnt_nx[q] = cnt_nx[q] + 1'b1;
      end
      if (free_req[q] && (cnt[q] != '0)) begin
        cnt_nx[q] = cnt_nx[q] - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int q = 0; q < NQ; q++) begin
        cnt[q]  <= '0;
        wptr[q] <= '0;
      end
      full_flag <= 1'b0;
    end else begin
      for (int q = 0; q < NQ; q++) begin
        cnt[q] <= cnt_nx[q];
      end
      if (wr_fire) begin
        wptr[act_q] <= (wptr[act_q] == SLOT_TOP) ? '0 : wptr[act_q] + 1'b1;
      end
      full_flag <= (cnt_nx[act_next] == CNT_MAX);
    end
  end
endmodule

// File: rtl/mq_store.sv
`timescale 1ns/1ps
module mq_store #(
  parameter int unsigned DW    = 32,
  parameter int unsigned WORDS = 2048,
  parameter int unsigned AW    = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] ram [WORDS];

  always_ff @(posedge clk) begin
    if (we) begin
      ram[waddr] <= wdata;
    end
    rdata <= ram[raddr];
  end
endmodule

// File: rtl/mq_write_port.sv
`timescale 1ns/1ps
module mq_write_port #(
  parameter int unsigned DW     = 32,
  parameter int unsigned NQ     = 128,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned SW_LAT = 4,
  parameter int unsigned QAW    = mq_pkg::idx_width(NQ),
  parameter int unsigned PW     = mq_pkg::idx_width(DEPTH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en_n,
  input  logic [DW-1:0]  wr_data,
  input  logic           sel_en,
  input  logic [QAW-1:0] sel_addr,
  input  logic [NQ-1:0]  free_req,
  input  logic [QAW-1:0] look_q,
  input  logic [PW-1:0]  look_slot,
  output logic           full_flag,
  output logic [QAW-1:0] active_q,
  output logic [DW-1:0]  look_data
);
  localparam int unsigned CW    = mq_pkg::cnt_width(DEPTH);
  localparam int unsigned WORDS = NQ * DEPTH;
  localparam int unsigned AW    = mq_pkg::idx_width(WORDS);

  logic [QAW-1:0] act_next;
  logic           wr_fire;
  logic [PW-1:0]  wr_slot;
  logic [AW-1:0]  waddr;
  logic [AW-1:0]  raddr;

  mq_sel_pipe #(.NQ(NQ), .QAW(QAW), .LAT(SW_LAT)) u_sel (
    .clk(clk), .rst(rst), .sel_en(sel_en), .sel_addr(sel_addr),
    .act_q(active_q), .act_next(act_next)
  );

  mq_occupancy #(.NQ(NQ), .DEPTH(DEPTH), .QAW(QAW), .PW(PW), .CW(CW)) u_occ (
    .clk(clk), .rst(rst), .act_q(active_q), .act_next(act_next),
    .wr_req(!wr_en_n), .free_req(free_req), .wr_fire(wr_fire),
    .wr_slot(wr_slot), .full_flag(full_flag)
  );

  assign waddr = AW'(32'(active_q) * DEPTH + 32'(wr_slot));
  assign raddr = AW'(32'(look_q) * DEPTH + 32'(look_slot));

  mq_store #(.DW(DW), .WORDS(WORDS), .AW(AW)) u_ram (
    .clk(clk), .we(wr_fire), .waddr(waddr), .wdata(wr_data),
    .raddr(raddr), .rdata(look_data)
  );
endmodule

// File: rtl/mq_write_port_chk.sv
`timescale 1ns/1ps
module mq_write_port_chk #(
  parameter int unsigned QAW = 7,
  parameter int unsigned LAT = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           wr_en_n,
  input logic           sel_en,
  input logic           full_flag,
  input logic [QAW-1:0] active_q,
  input logic           wr_fire
);
  logic [LAT-1:0] hist;

  always_ff @(posedge clk) begin
    if (rst) hist <= '0;
    else     hist <= {hist[LAT-2:0], sel_en};
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) rst |=> (!full_flag && active_q == '0));

  // R2
  switch_source_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(active_q) |-> hist[LAT-1]);

  // R5
  no_enable_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en_n |-> !wr_fire);

  // R8
  full_block_chk: assert property (@(posedge clk) disable iff (rst)
    full_flag |-> !wr_fire);

  // R4
  write_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en_n && !full_flag) |-> wr_fire);
endmodule

bind mq_write_port mq_write_port_chk #(.QAW(QAW), .LAT(SW_LAT)) u_chk (
  .clk(clk), .rst(rst), .wr_en_n(wr_en_n), .sel_en(sel_en),
  .full_flag(full_flag), .active_q(active_q), .wr_fire(wr_fire)
);

// File: tb/mq_write_port_bench.sv
`timescale 1ns/1ps
module mq_write_port_bench;
  localparam int DW = 32, NQ = 128, DEPTH = 16, LAT = 4;
  localparam int QAW = 7, PW = 4;

  logic clk = 0;
  logic rst, wen_n, sel_en;
  logic [DW-1:0]  wdata;
  logic [QAW-1:0] sel_addr, look_q, active_q;
  logic [PW-1:0]  look_slot;
  logic [NQ-1:0]  free_req;
  logic           full_flag;
  logic [DW-1:0]  look_data;

  int n_chk = 0, n_fail = 0;

  // behavioural model
  int mcnt [NQ];
  int mptr [NQ];
  logic [DW-1:0] mmem [NQ][DEPTH];
  int mact;
  bit mfull;
  bit pv [LAT-1];
  int pa [LAT-1];

  always #2.5 clk = ~clk;

  mq_write_port #(.DW(DW), .NQ(NQ), .DEPTH(DEPTH), .SW_LAT(LAT)) u_mq_write_port (
    .clk(clk), .rst(rst), .wr_en_n(wen_n), .wr_data(wdata), .sel_en(sel_en),
    .sel_addr(sel_addr), .free_req(free_req), .look_q(look_q), .look_slot(look_slot),
    .full_flag(full_flag), .active_q(active_q), .look_data(look_data)
  );

  task automatic chk(string tag, longint unsigned act, longint unsigned exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    int old [NQ];
    if (rst) begin
      for (int q = 0; q < NQ; q++) begin mcnt[q] = 0; mptr[q] = 0; end
      for (int i = 0; i < LAT-1; i++) pv[i] = 0;
      mact = 0; mfull = 0;
      return;
    end
    for (int q = 0; q < NQ; q++) old[q] = mcnt[q];
    if (!wen_n && old[mact] < DEPTH) begin
      mmem[mact][mptr[mact]] = wdata;
      mptr[mact] = (mptr[mact] + 1) % DEPTH;
      mcnt[mact]++;
    end
    for (int q = 0; q < NQ; q++)
      if (free_req[q] && old[q] > 0) mcnt[q]--;
    if (pv[LAT-2]) mact = pa[LAT-2];
    for (int i = LAT-2; i > 0; i--) begin pv[i] = pv[i-1]; pa[i] = pa[i-1]; end
    pv[0] = sel_en; pa[0] = sel_addr;
    mfull = (mcnt[mact] == DEPTH);
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("R2 R11 active queue vs model", active_q, mact);
    chk("R6 R7 full flag vs model", full_flag, mfull);
  endtask

  task automatic look(int q, int s, string tag);
    wen_n = 1; sel_en = 0;
    look_q = QAW'(q); look_slot = PW'(s);
    tick();
    chk(tag, look_data, mmem[q][s]);
  endtask

  task automatic select(int q);
    sel_en = 1; sel_addr = QAW'(q); tick(); sel_en = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1; wen_n = 1; sel_en = 0; sel_addr = 0; wdata = 0;
    free_req = '0; look_q = 0; look_slot = 0;
    repeat (3) tick();
    rst = 0; tick();
    chk("R1 full after reset", full_flag, 0);
    chk("R1 active after reset", active_q, 0);

    // R4 basic writes to queue 0
    for (int i = 0; i < 5; i++) begin wen_n = 0; wdata = 32'hA000 + i; tick(); end
    for (int i = 0; i < 5; i++) look(0, i, "R4 word stored in queue 0");
    chk("R4 slot 2 value", mmem[0][2], 32'hA002);

    // R3 select queue 3 while streaming
    wen_n = 0; wdata = 32'hB000; sel_en = 1; sel_addr = 3; tick(); sel_en = 0;
    for (int i = 1; i < 8; i++) begin wdata = 32'hB000 + i; tick(); end
    wen_n = 1;
    look(0, 8, "R3 last latency word in old queue");
    chk("R3 old queue got 4th word", look_data, 32'hB003);
    look(3, 0, "R3 first word in new queue");
    chk("R3 new queue first word", look_data, 32'hB004);

    // R5 enable high stores nothing
    for (int i = 0; i < 3; i++) begin wdata = 32'hDEAD0000 + i; tick(); end
    wen_n = 0; wdata = 32'hC000; tick(); wen_n = 1;
    look(3, 4, "R5 pointer held while disabled");
    chk("R5 next slot value", look_data, 32'hC000);

    // R2 select with enable high, exact latency
    wen_n = 1; select(5); tick(); tick();
    chk("R2 not yet switched", active_q, 3);
    tick();
    chk("R2 switched on fourth edge", active_q, 5);
    select(3); repeat (3) tick();

    // R6 fill queue 3 (5 words present)
    for (int i = 0; i < 11; i++) begin
      chk("R6 not full before last word", full_flag, 0);
      wen_n = 0; wdata = 32'hD000 + i; tick();
    end
    chk("R6 full after sixteenth word", full_flag, 1);

    // R8 writes discarded
    for (int i = 0; i < 3; i++) begin wdata = 32'hEE00 + i; tick(); end
    look(3, 0, "R8 slot 0 untouched by blocked write");
    chk("R8 slot 0 value", look_data, 32'hB004);

    // R7 switch to empty queue 5 then back to full queue 3
    wen_n = 0; wdata = 32'hF000; select(5); tick(); tick();
    chk("R7 still full before switch", full_flag, 1);
    tick();
    chk("R7 flag drops with switch", full_flag, 0);
    select(3); tick(); tick();
    chk("R7 flag low before switch back", full_flag, 0);
    tick();
    chk("R7 flag rises with switch", full_flag, 1);
    chk("R7 active queue 3", active_q, 3);
    wen_n = 1;

    // R9 free one word from queue 3, write refills slot 0
    free_req[3] = 1; tick(); free_req[3] = 0;
    chk("R9 flag clears after free", full_flag, 0);
    wen_n = 0; wdata = 32'h1234_5678; tick(); wen_n = 1;
    chk("R9 full again", full_flag, 1);
    look(3, 0, "R9 refilled slot 0");
    // empty queue free ignored
    free_req[9] = 1; tick(); tick(); free_req[9] = 0;

    // R10 back-to-back selects
    wen_n = 0;
    sel_en = 1; sel_addr = 7; tick(); sel_addr = 9; tick(); sel_addr = 11; tick();
    sel_en = 0; tick();
    chk("R10 first select", active_q, 7);
    tick();
    chk("R10 second select", active_q, 9);
    tick();
    chk("R10 third select", active_q, 11);
    wen_n = 1;
    // queue 9 must be empty after ignored frees plus one word written during switch
    // R11 hold
    repeat (20) tick();
    chk("R11 active holds", active_q, 11);

    // random phase on queues 0..3
    for (int c = 0; c < 3000; c++) begin
      wen_n = ($urandom_range(0, 3) == 0);
      wdata = $urandom;
      sel_en = ($urandom_range(0, 5) == 0);
      sel_addr = QAW'($urandom_range(0, 3));
      free_req = '0;
      for (int q = 0; q < 4; q++) free_req[q] = ($urandom_range(0, 4) == 0);
      tick();
    end
    wen_n = 1; sel_en = 0; free_req = '0;
    for (int q = 0; q < 4; q++)
      for (int s = 0; s < DEPTH; s++) look(q, s, "R4 R9 random phase contents");

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule